// File: doc/BRIEF.md
# Hash Chain Stage Controller

This block drives one pass of a batch of nonces through a single hash stage of a multi-hash chain. The stage is a fixed-latency pipeline with a valid signal and no ready signal. Configuration inputs hold a block header, a 512-bit target, a starting nonce, a batch count and a stage role. A one-cycle `start` pulse latches all of them and begins the pass.

The role selects the data source and the destination. In the head role the controller builds each hash input from the header, with a 32-bit nonce field overwritten by the starting nonce plus the issue index. In the middle and last roles it takes stored mid-states in order from a memory read stream instead. Results from head and middle passes go unchanged to a mid-state store stream. In a last pass each result is compared against the target, and qualifying nonces are queued in a small result FIFO that the host reads. No nonce travels with the data: a result's nonce is the starting nonce plus its position in the ordered output stream.

An input-side pause blocks new issues while downstream space is not guaranteed. The host raises `start`, waits for `done`, then drains the result FIFO.

Top module: `hash_stage_ctrl`

## Requirements
- R1: After reset, `done`, `ovf`, `hin_valid`, `st_valid`, `res_valid` and `mem_rd_ready` are all low.
- R2: In the head role (`cfg_role` = 0), each issue presents on `hin_data`, one cycle later, the latched header with bits [NONCE_POS +: 32] replaced by the starting nonce plus the zero-based issue index.
- R3: In the middle (`cfg_role` = 1 or 3) and last (`cfg_role` = 2) roles, `mem_rd_ready` is high only while a pass is active, fewer than the batch count have been issued and `hin_pause` is low. Each accepted word appears unchanged on `hin_data` one cycle later, in order.
- R4: While `hin_pause` is high, no input is issued: `hin_valid` is low in the following cycle.
- R5: In the head and middle roles, every counted hash result appears unchanged on `st_data` with `st_valid` one cycle later.
- R6: In the last role, `st_valid` stays low. A result qualifies when it is less than or equal to the target, both read as unsigned 512-bit values with bit 511 the most significant. An equal result qualifies.
- R7: The nonce queued for a qualifying result is the starting nonce plus the zero-based position of that result among the hash results of the pass.
- R8: `done` rises in the cycle after the batch-count-th result is consumed. A `start` clears it. A `start` with a batch count of 0 sets it at once.
- R9: A qualifying nonce that arrives when the result FIFO holds FIFO_DEPTH entries is dropped, and `ovf` is set. `ovf` stays set until the next `start`, which also empties the FIFO.
- R10: `res_valid` is high while the FIFO is non-empty. `res_nonce` shows the oldest entry, and `res_pop` removes it, so nonces come out in first-in first-out order.
- R11: A pass never issues more inputs than the batch count and never takes more memory words than that. Results arriving after the count is reached are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a pass and latches the configuration |
| cfg_role | input | 2 | 0 head, 1 or 3 middle, 2 last |
| cfg_header | input | DATA_W | Block header used in the head role |
| cfg_target | input | DATA_W | Target for the last role |
| cfg_nonce0 | input | NONCE_W | Starting nonce |
| cfg_count | input | CNT_W | Batch count |
| hin_pause | input | 1 | Blocks issuing new inputs |
| mem_rd_valid | input | 1 | Stored mid-state available |
| mem_rd_data | input | DATA_W | Stored mid-state |
| mem_rd_ready | output | 1 | Mid-state accepted this cycle when valid |
| hin_valid | output | 1 | Input to the hash stage is valid |
| hin_data | output | DATA_W | Input to the hash stage |
| hout_valid | input | 1 | Hash stage result valid |
| hout_data | input | DATA_W | Hash stage result |
| st_valid | output | 1 | Mid-state to store is valid |
| st_data | output | DATA_W | Mid-state to store |
| res_valid | output | 1 | Result FIFO not empty |
| res_nonce | output | NONCE_W | Oldest queued nonce |
| res_pop | input | 1 | Removes the oldest queued nonce |
| done | output | 1 | Pass complete |
| ovf | output | 1 | Sticky result FIFO overflow |

## Verification
The hardest situation to reach from the ports is a full result FIFO during a last pass. Nonces only enter it after a stage latency, and only when hash values fall at or below the target. The bench therefore runs a last pass with an all-ones target and no pops, so every result qualifies and the FIFO overflows. A following zero-count pass then shows the flush and the cleared flag. The exact-equality boundary is reached by building a memory word whose modelled hash equals the target, next to a word whose hash is one bit higher.

// File: rtl/hash_stage_ctrl.sv
module hash_stage_ctrl #(
  parameter int DATA_W     = 512,
  parameter int NONCE_W    = 32,
  parameter int NONCE_POS  = 0,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         cfg_role,
  input  logic [DATA_W-1:0]  cfg_header,
  input  logic [DATA_W-1:0]  cfg_target,
  input  logic [NONCE_W-1:0] cfg_nonce0,
  input  logic [CNT_W-1:0]   cfg_count,
  input  logic               hin_pause,
  input  logic               mem_rd_valid,
  input  logic [DATA_W-1:0]  mem_rd_data,
  output logic               mem_rd_ready,
  output logic               hin_valid,
  output logic [DATA_W-1:0]  hin_data,
  input  logic               hout_valid,
  input  logic [DATA_W-1:0]  hout_data,
  output logic               st_valid,
  output logic [DATA_W-1:0]  st_data,
  output logic               res_valid,
  output logic [NONCE_W-1:0] res_nonce,
  input  logic               res_pop,
  output logic               done,
  output logic               ovf
);
  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [1:0] ROLE_HEAD = 2'd0;
  localparam logic [1:0] ROLE_LAST = 2'd2;

  logic [1:0]         role_q;
  logic [DATA_W-1:0]  header_q, target_q, head_word;
  logic [NONCE_W-1:0] nonce0_q;
  logic [CNT_W-1:0]   count_q, issued, received;
  logic               active;
  logic [NONCE_W-1:0] fifo_mem [FIFO_DEPTH];
  logic [AW-1:0]      wp, rp;
  logic [AW:0]        fcnt;

  wire is_head   = role_q == ROLE_HEAD;
  wire is_last   = role_q == ROLE_LAST;
  wire can_issue = active && (issued != count_q) && !hin_pause;
  wire take_out  = active && hout_valid && (received != count_q);
  wire hit       = is_last && take_out && (hout_data <= target_q);
  wire push      = hit && (fcnt != (AW+1)'(FIFO_DEPTH));
  wire pop       = res_pop && (fcnt != '0);

  assign mem_rd_ready = can_issue && !is_head;
  assign res_valid    = fcnt != '0;
  assign res_nonce    = fifo_mem[rp];

  always_comb begin
    head_word = header_q;
    head_word[NONCE_POS +: NONCE_W] = nonce0_q + NONCE_W'(issued);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      role_q <= '0; header_q <= '0; target_q <= '0; nonce0_q <= '0; count_q <= '0;
      issued <= '0; received <= '0; active <= 1'b0; done <= 1'b0; ovf <= 1'b0;
      hin_valid <= 1'b0; hin_data <= '0; st_valid <= 1'b0; st_data <= '0;
      wp <= '0; rp <= '0; fcnt <= '0;
    end else if (start) begin
      role_q <= cfg_role; header_q <= cfg_header; target_q <= cfg_target;
      nonce0_q <= cfg_nonce0; count_q <= cfg_count;
      issued <= '0; received <= '0;
      active <= cfg_count != '0;
      done   <= cfg_count == '0;
      ovf <= 1'b0; hin_valid <= 1'b0; st_valid <= 1'b0;
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      hin_valid <= can_issue && (is_head || mem_rd_valid);
      if (can_issue && is_head) begin
        hin_data <= head_word;
        issued   <= issued + 1'b1;
      end else if (mem_rd_ready && mem_rd_valid) begin
        hin_data <= mem_rd_data;
        issued   <= issued + 1'b1;
      end
      st_valid <= take_out && !is_last;
      if (take_out && !is_last) st_data <= hout_data;
      if (take_out) begin
        received <= received + 1'b1;
        if (received + CNT_W'(1) == count_q) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
      if (hit && !push) ovf <= 1'b1;
      if (push) wp <= (wp == AW'(FIFO_DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(FIFO_DEPTH-1)) ? '0 : rp + 1'b1;
      fcnt <= fcnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !start && push) fifo_mem[wp] <= nonce0_q + NONCE_W'(received);
  end
endmodule

// File: rtl/hash_stage_ctrl_chk.sv
module hash_stage_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] cfg_count,
  input logic             hin_pause,
  input logic             hin_valid,
  input logic             mem_rd_ready,
  input logic             st_valid,
  input logic             is_last,
  input logic             res_valid,
  input logic             done,
  input logic             ovf
);
  p_pause_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hin_pause |=> !hin_valid);

  p_ready_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hin_pause || done) |-> !mem_rd_ready);

  p_no_store_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_last |-> !st_valid);

  p_done_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (done == ($past(cfg_count) == '0)));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !start) |=> ovf);

  p_flush_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !res_valid);
endmodule

bind hash_stage_ctrl hash_stage_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_count(cfg_count),
  .hin_pause(hin_pause), .hin_valid(hin_valid), .mem_rd_ready(mem_rd_ready),
  .st_valid(st_valid), .is_last(is_last), .res_valid(res_valid),
  .done(done), .ovf(ovf)
);

// File: tb/hash_stage_ctrl_tb.sv
module hash_stage_ctrl_tb;
  localparam int DW = 512, NW = 32, NP = 96, CW = 16, DEPTH = 4, LAT = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] cfg_role = 0;
  logic [DW-1:0] cfg_header = 0, cfg_target = 0;
  logic [NW-1:0] cfg_nonce0 = 0;
  logic [CW-1:0] cfg_count = 0;
  logic hin_pause = 0, mem_rd_valid = 0, res_pop = 0;
  logic [DW-1:0] mem_rd_data = 0;
  logic mem_rd_ready, hin_valid, st_valid, res_valid, done, ovf;
  logic [DW-1:0] hin_data, st_data;
  logic [NW-1:0] res_nonce;
  logic hout_valid;
  logic [DW-1:0] hout_data;

  int checks = 0, fails = 0;
  bit pause_en = 0, mem_en = 0, pop_en = 0;
  logic [DW-1:0] memq[$];

  always #4 clk = ~clk;

  hash_stage_ctrl #(.DATA_W(DW), .NONCE_W(NW), .NONCE_POS(NP), .CNT_W(CW), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_role(cfg_role), .cfg_header(cfg_header),
    .cfg_target(cfg_target), .cfg_nonce0(cfg_nonce0), .cfg_count(cfg_count),
    .hin_pause(hin_pause), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_rd_ready(mem_rd_ready), .hin_valid(hin_valid), .hin_data(hin_data),
    .hout_valid(hout_valid), .hout_data(hout_data), .st_valid(st_valid), .st_data(st_data),
    .res_valid(res_valid), .res_nonce(res_nonce), .res_pop(res_pop), .done(done), .ovf(ovf));

  function automatic logic [DW-1:0] hfun(logic [DW-1:0] d);
    return {(d[31:0] * 32'h9E3779B1) ^ d[63:32], d[479:0]};
  endfunction

  function automatic logic [DW-1:0] rand_word();
    logic [DW-1:0] w;
    for (int i = 0; i < DW/32; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  // fixed-latency hash stage model
  logic pv [LAT];
  logic [DW-1:0] pd [LAT];
  always @(posedge clk) begin
    pv[0] <= rst_n && hin_valid;
    pd[0] <= hin_data;
    for (int i = 1; i < LAT; i++) begin
      pv[i] <= rst_n && pv[i-1];
      pd[i] <= pd[i-1];
    end
  end
  assign hout_valid = pv[LAT-1] === 1'b1;
  assign hout_data  = hfun(pd[LAT-1]);

  // stimulus drivers, applied 1 ns after the edge
  always @(posedge clk) begin
    if (mem_rd_valid && mem_rd_ready) void'(memq.pop_front());
    #1;
    hin_pause    = pause_en && ($urandom % 4 == 0);
    mem_rd_valid = mem_en && memq.size() > 0 && ($urandom % 3 != 0);
    mem_rd_data  = (memq.size() > 0) ? memq[0] : '0;
    res_pop      = pop_en && ($urandom % 2 == 0);
  end

  // behavioural reference model
  logic [1:0] m_role;
  logic [DW-1:0] m_hdr, m_tgt, e_hd, e_sd;
  logic [NW-1:0] m_n0;
  int m_cnt, m_iss, m_rcv;
  bit m_act, m_done, m_ovf, e_hv, e_sv;
  logic [NW-1:0] rq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_done = 0; m_ovf = 0; e_hv = 0; e_sv = 0; rq.delete();
      m_iss = 0; m_rcv = 0; m_cnt = 0; m_role = 0;
    end else if (start) begin
      m_role = cfg_role; m_hdr = cfg_header; m_tgt = cfg_target; m_n0 = cfg_nonce0;
      m_cnt = int'(cfg_count); m_iss = 0; m_rcv = 0;
      m_act = m_cnt != 0; m_done = m_cnt == 0; m_ovf = 0; e_hv = 0; e_sv = 0; rq.delete();
    end else begin
      bit ci, full;
      ci = m_act && m_iss < m_cnt && !hin_pause;
      e_hv = 0;
      if (ci && m_role == 0) begin
        e_hv = 1; e_hd = m_hdr; e_hd[NP +: NW] = NW'(m_n0 + NW'(m_iss)); m_iss++;
      end else if (ci && mem_rd_valid) begin
        e_hv = 1; e_hd = mem_rd_data; m_iss++;
      end
      e_sv = 0;
      full = rq.size() >= DEPTH;
      if (res_pop && rq.size() > 0) void'(rq.pop_front());
      if (hout_valid && m_act && m_rcv < m_cnt) begin
        if (m_role != 2) begin e_sv = 1; e_sd = hout_data; end
        else if (hout_data <= m_tgt) begin
          if (full) m_ovf = 1; else rq.push_back(NW'(m_n0 + NW'(m_rcv)));
        end
        m_rcv++;
        if (m_rcv == m_cnt) begin m_act = 0; m_done = 1; end
      end
    end
  end

  task automatic chk(string tag, bit ok, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit er;
      er = m_act && m_iss < m_cnt && !hin_pause && m_role != 0;
      chk("R3 R4 R11 hin_valid", hin_valid == e_hv, DW'(hin_valid), DW'(e_hv));
      if (e_hv) chk("R2 R3 hin_data", hin_data == e_hd, hin_data, e_hd);
      chk("R3 mem_rd_ready", mem_rd_ready == er, DW'(mem_rd_ready), DW'(er));
      chk("R5 R6 st_valid", st_valid == e_sv, DW'(st_valid), DW'(e_sv));
      if (e_sv) chk("R5 st_data", st_data == e_sd, st_data, e_sd);
      chk("R10 res_valid", res_valid == (rq.size() > 0), DW'(res_valid), DW'(rq.size() > 0));
      if (rq.size() > 0) chk("R7 R10 res_nonce", res_nonce == rq[0], DW'(res_nonce), DW'(rq[0]));
      chk("R8 done", done == m_done, DW'(done), DW'(m_done));
      chk("R9 ovf", ovf == m_ovf, DW'(ovf), DW'(m_ovf));
    end
  end

  task automatic run_pass(logic [1:0] role, int cnt, logic [DW-1:0] tgt, logic [NW-1:0] n0);
    int t = 0;
    cfg_role = role; cfg_count = CW'(cnt); cfg_target = tgt; cfg_nonce0 = n0;
    cfg_header = rand_word();
    @(posedge clk); #1; start = 1;
    @(posedge clk); #1; start = 0;
    while (!done && t < 5000) begin @(posedge clk); t++; end
    if (t >= 5000) begin fails++; checks++; $display("FAIL R8 watchdog actual=0 expected=1"); end
    repeat (LAT + 3) @(posedge clk);
    @(negedge clk);
    chk("R8 done after pass", done == 1'b1, DW'(done), DW'(1));
  endtask

  initial begin
    logic [DW-1:0] w0;
    #300_000_000;
    fails++; checks++;
    $display("FAIL R8 global watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] w0, w1, all1;
    all1 = '1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 done", done == 0, DW'(done), 0);
    chk("R1 ovf", ovf == 0, DW'(ovf), 0);
    chk("R1 hin_valid", hin_valid == 0, DW'(hin_valid), 0);
    chk("R1 st_valid", st_valid == 0, DW'(st_valid), 0);
    chk("R1 res_valid", res_valid == 0, DW'(res_valid), 0);
    chk("R1 mem_rd_ready", mem_rd_ready == 0, DW'(mem_rd_ready), 0);
    @(posedge clk); #1; rst_n = 1;

    // head role with pauses (R2, R4, R5)
    pause_en = 1;
    run_pass(2'd0, 12, all1, 32'hFFFF_FFF8);

    // middle role, extra words left unread (R3, R5, R11)
    mem_en = 1;
    for (int i = 0; i < 13; i++) memq.push_back(rand_word());
    run_pass(2'd1, 10, all1, 32'd100);
    chk("R11 leftover words", memq.size() == 3, DW'(memq.size()), DW'(3));
    memq.delete();

    // last role with pops (R6, R7, R10)
    pop_en = 1;
    for (int i = 0; i < 20; i++) memq.push_back(rand_word());
    run_pass(2'd2, 20, {32'h8000_0000, {480{1'b1}}}, 32'd5000);
    repeat (DEPTH + 4) @(posedge clk);
    @(negedge clk);
    chk("R10 fifo drained", res_valid == 0, DW'(res_valid), 0);

    // overflow with no pops (R9)
    pop_en = 0; pause_en = 0;
    for (int i = 0; i < 16; i++) memq.push_back(rand_word());
    run_pass(2'd2, 16, all1, 32'd7);
    chk("R9 ovf set", ovf == 1, DW'(ovf), 1);
    chk("R9 fifo full head", res_nonce == 32'd7, DW'(res_nonce), DW'(7));

    // zero count: done at once, flush and clear (R8, R9)
    cfg_count = 0; cfg_role = 2'd2;
    @(posedge clk); #1; start = 1;
    @(posedge clk); #1; start = 0;
    @(negedge clk);
    chk("R8 zero count done", done == 1, DW'(done), 1);
    chk("R9 ovf cleared", ovf == 0, DW'(ovf), 0);
    chk("R9 fifo flushed", res_valid == 0, DW'(res_valid), 0);
    chk("R11 no issue on zero count", hin_valid == 0, DW'(hin_valid), 0);

    // equality boundary (R6)
    w0 = rand_word(); w0[100] = 1'b0;
    w1 = w0; w1[100] = 1'b1;
    memq.push_back(w0); memq.push_back(w1);
    run_pass(2'd2, 2, hfun(w0), 32'd42);
    chk("R6 equal qualifies", res_valid == 1 && res_nonce == 32'd42, DW'(res_nonce), DW'(42));
    @(posedge clk); #1; res_pop = 1;
    @(posedge clk); #1; res_pop = 0;
    @(negedge clk);
    chk("R6 greater rejected", res_valid == 0, DW'(res_valid), 0);

    mem_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule